// File: doc/BRIEF.md
# Tagged Two-Bit Branch Predictor Table

This block is a direct-mapped table that remembers recently resolved branches. Each of its slots keeps a valid flag, the upper part of the branch address as a tag, a two-bit hysteresis counter and the last taken target. A fetch stage presents a program counter on the lookup port and receives, in the same cycle, whether the table knows this branch, whether it should be predicted taken, and where it would go.

Once a branch resolves, the execute stage reports the branch address, the real outcome and the real target on the update port. If the slot does not already hold that branch, the slot is overwritten with a fresh entry. If it does, the two-bit counter moves one step and, for a taken branch, the target is refreshed. Updates are written at the clock edge, so a lookup in the same cycle as an update to the same slot sees the contents from before the update.

Top module: `bp_tagged_table`

## Requirements
- R1: After reset every slot is invalid, so every lookup reports lk_hit=0.
- R2: A PC selects slot PC[7:2] and is tagged by PC[31:8]; a lookup hits only when that slot is valid and its tag equals PC[31:8], so a PC with the same index but another tag misses.
- R3: A lookup miss reports lk_taken=0 and lk_target=0.
- R4: On a hit, counter values 2'b10 and 2'b11 give lk_taken=1, values 2'b00 and 2'b01 give lk_taken=0, and lk_target is the stored target.
- R5: An update that misses fills the slot: valid set, tag and target written, counter 2'b11 when taken and 2'b00 when not taken.
- R6: An update that hits steps the counter: 00 goes to 01 on taken and stays on not taken; 01 goes to 11 on taken and to 00 on not taken; 11 stays on taken and goes to 10 on not taken; 10 goes to 11 on taken and to 00 on not taken.
- R7: A hitting update that is taken overwrites the stored target with upd_target; a hitting update that is not taken leaves the target unchanged.
- R8: A lookup in the same cycle as an update to the same slot reports the slot's contents from before that update; the new contents are visible from the next cycle.
- R9: An update whose PC aliases a valid slot with another tag evicts it, after which the old branch misses and the new one hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Address of the branch being predicted |
| lk_hit | output | 1 | Slot holds this branch |
| lk_taken | output | 1 | Prediction: branch taken |
| lk_target | output | 32 | Predicted target, zero on a miss |
| upd_en | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved target address |

## Verification
A wrong counter step stays hidden until the direction bit flips, so the bench walks every counter state with both outcomes and reads the lookup after each update; an error in the weak states shows one to two updates later as a wrong lk_taken. A broken tag compare or index slice shows at once as a false hit on an aliasing PC, and a target written on the wrong condition shows on the next hitting lookup as a wrong lk_target. Random traffic over a small pool of colliding addresses compares every lookup with a bench model each cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        CTR_NT       = 2'b00,
        CTR_NT_AGAIN = 2'b01,
        CTR_T_AGAIN  = 2'b10,
        CTR_T        = 2'b11
    } ctr_e;
endpackage

// File: rtl/bp_ctr_step.sv
module bp_ctr_step
    import bp_pkg::*;
(
    input  ctr_e cur_i,
    input  logic taken_i,
    output ctr_e nxt_o
);
    always_comb begin
        unique case (cur_i)
            CTR_NT:       nxt_o = taken_i ? CTR_NT_AGAIN : CTR_NT;
            CTR_NT_AGAIN: nxt_o = taken_i ? CTR_T        : CTR_NT;
            CTR_T_AGAIN:  nxt_o = taken_i ? CTR_T        : CTR_NT;
            default:      nxt_o = taken_i ? CTR_T        : CTR_T_AGAIN;
        endcase
    end
endmodule

// File: rtl/bp_slot_array.sv
module bp_slot_array #(
    parameter int IDX_W = 6,
    parameter int ENT_W = 58
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_vld,
    output logic [ENT_W-1:0] ra_ent,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_vld,
    output logic [ENT_W-1:0] rb_ent,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [ENT_W-1:0] wdata
);
    localparam int SLOTS = 1 << IDX_W;

    typedef struct packed {
        logic [SLOTS-1:0] vld;
    } st_t;

    st_t              st_d, st_q;
    logic [ENT_W-1:0] mem_d [SLOTS];
    logic [ENT_W-1:0] mem_q [SLOTS];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SLOTS; i++) mem_d[i] = mem_q[i];
        if (we) begin
            st_d.vld[widx] = 1'b1;
            mem_d[widx]    = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
        for (int i = 0; i < SLOTS; i++) mem_q[i] <= mem_d[i];
    end

    assign ra_vld = st_q.vld[ra_idx];
    assign ra_ent = mem_q[ra_idx];
    assign rb_vld = st_q.vld[rb_idx];
    assign rb_ent = mem_q[rb_idx];

    // checker state: last write, held one cycle
    logic             chk_we_q;
    logic [IDX_W-1:0] chk_idx_q;
    logic [ENT_W-1:0] chk_dat_q;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_we_q <= 1'b0;
        else        chk_we_q <= we;
        chk_idx_q <= widx;
        chk_dat_q <= wdata;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_we_q |-> (st_q.vld[chk_idx_q] && mem_q[chk_idx_q] == chk_dat_q)); // R5
    AST_VALID_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld != '0) |=> ((st_q.vld & $past(st_q.vld)) == $past(st_q.vld))); // R1
endmodule

// File: rtl/bp_tagged_table.sv
module bp_tagged_table
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int OFS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam int TAG_W = PC_W - IDX_W - OFS_W;
    localparam int ENT_W = TAG_W + 2 + PC_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        ctr_e             ctr;
        logic [PC_W-1:0]  tgt;
    } ent_t;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             lk_vld, up_vld, up_hit;
    logic [ENT_W-1:0] lk_raw, up_raw, wr_raw;
    ent_t             lk_ent, up_ent, wr_ent;
    ctr_e             step_ctr;

    assign lk_idx = lk_pc[OFS_W +: IDX_W];
    assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
    assign up_idx = upd_pc[OFS_W +: IDX_W];
    assign up_tag = upd_pc[PC_W-1 -: TAG_W];

    bp_slot_array #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (lk_idx),
        .ra_vld (lk_vld),
        .ra_ent (lk_raw),
        .rb_idx (up_idx),
        .rb_vld (up_vld),
        .rb_ent (up_raw),
        .we     (upd_en),
        .widx   (up_idx),
        .wdata  (wr_raw)
    );

    assign lk_ent = ent_t'(lk_raw);
    assign up_ent = ent_t'(up_raw);
    assign up_hit = up_vld && (up_ent.tag == up_tag);

    bp_ctr_step u_step (
        .cur_i   (up_ent.ctr),
        .taken_i (upd_taken),
        .nxt_o   (step_ctr)
    );

    always_comb begin
        if (up_hit) begin
            wr_ent     = up_ent;
            wr_ent.ctr = step_ctr;
            if (upd_taken) wr_ent.tgt = upd_target;
        end else begin
            wr_ent.tag = up_tag;
            wr_ent.ctr = upd_taken ? CTR_T : CTR_NT;
            wr_ent.tgt = upd_target;
        end
    end
    assign wr_raw = wr_ent;

    always_comb begin
        lk_hit    = lk_vld && (lk_ent.tag == lk_tag);
        lk_taken  = lk_hit && lk_ent.ctr[1];
        lk_target = lk_hit ? lk_ent.tgt : '0;
    end

    AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_taken && lk_target == '0)); // R3
    AST_NT_HIT_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && up_hit && !upd_taken) |-> (wr_ent.tgt == up_ent.tgt)); // R7
    AST_STRONG_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && up_hit && upd_taken && up_ent.ctr == CTR_T) |-> (wr_ent.ctr == CTR_T)); // R6
endmodule

// File: tb/bp_tagged_table_test.sv
`timescale 1ns/1ps
module bp_tagged_table_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_target;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bp_tagged_table uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_taken(lk_taken), .lk_target(lk_target), .upd_en(upd_en),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
    );

    // bench model
    bit          m_vld [64];
    logic [23:0] m_tag [64];
    logic [1:0]  m_ctr [64];
    logic [31:0] m_tgt [64];

    function automatic logic [1:0] next_ctr(input logic [1:0] c, input logic t);
        case (c)
            2'b00:   return t ? 2'b01 : 2'b00;
            2'b01:   return t ? 2'b11 : 2'b00;
            2'b10:   return t ? 2'b11 : 2'b00;
            default: return t ? 2'b11 : 2'b10;
        endcase
    endfunction

    task automatic check(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic step(input string rq, input logic [31:0] lpc, input logic en,
                        input logic [31:0] upc, input logic tk, input logic [31:0] tgt);
        int   li, ui;
        logic eh;
        @(negedge clk);
        lk_pc = lpc; upd_en = en; upd_pc = upc; upd_taken = tk; upd_target = tgt;
        #1;
        li = int'(lpc[7:2]);
        eh = m_vld[li] && (m_tag[li] == lpc[31:8]);
        check(rq, "hit", {31'b0, lk_hit}, {31'b0, eh});
        check(rq, "taken", {31'b0, lk_taken}, {31'b0, eh && m_ctr[li][1]});
        check(rq, "target", lk_target, eh ? m_tgt[li] : 32'h0);
        @(posedge clk);
        if (en) begin
            ui = int'(upc[7:2]);
            if (m_vld[ui] && m_tag[ui] == upc[31:8]) begin
                m_ctr[ui] = next_ctr(m_ctr[ui], tk);
                if (tk) m_tgt[ui] = tgt;
            end else begin
                m_vld[ui] = 1'b1; m_tag[ui] = upc[31:8];
                m_tgt[ui] = tgt;  m_ctr[ui] = tk ? 2'b11 : 2'b00;
            end
        end
    endtask

    function automatic logic [31:0] mk_pc(input logic [23:0] tag, input logic [5:0] idx);
        return {tag, idx, 2'b00};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pb, pc;
        logic [31:0] pool [8];
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: everything misses after reset
        for (int i = 0; i < 4; i++) step("R1", mk_pc(24'h000123 + i, 6'(i * 17)), 1'b0, 0, 1'b0, 0);

        pa = mk_pc(24'hABCDEF, 6'd5);
        pb = mk_pc(24'h123456, 6'd5);    // aliases pa
        pc = mk_pc(24'hABCDEF, 6'd6);

        // R8: lookup during allocating update sees the old (empty) slot
        step("R8", pa, 1'b1, pa, 1'b1, 32'h0000_4000);
        // R5: taken allocation, counter 11
        step("R5", pa, 1'b0, 0, 1'b0, 0);
        // R2: same tag, other index, misses
        step("R2", pc, 1'b0, 0, 1'b0, 0);
        step("R2", pb, 1'b0, 0, 1'b0, 0);
        // R6: walk all counter states
        step("R6", pa, 1'b1, pa, 1'b0, 32'h0);          // 11 -> 10
        step("R6", pa, 1'b1, pa, 1'b0, 32'h0);          // 10 -> 00
        step("R6", pa, 1'b1, pa, 1'b0, 32'h0);          // 00 -> 00
        step("R6", pa, 1'b1, pa, 1'b1, 32'h0000_4000);  // 00 -> 01
        step("R6", pa, 1'b1, pa, 1'b0, 32'h0);          // 01 -> 00
        step("R6", pa, 1'b1, pa, 1'b1, 32'h0000_4000);  // 00 -> 01
        step("R6", pa, 1'b1, pa, 1'b1, 32'h0000_4000);  // 01 -> 11
        step("R6", pa, 1'b1, pa, 1'b0, 32'h0);          // 11 -> 10
        step("R6", pa, 1'b1, pa, 1'b1, 32'h0000_4000);  // 10 -> 11
        step("R4", pa, 1'b0, 0, 1'b0, 0);
        // R7: taken hit rewrites target, not-taken hit keeps it
        step("R7", pa, 1'b1, pa, 1'b1, 32'h0000_8800);
        step("R7", pa, 1'b1, pa, 1'b0, 32'hDEAD_BEEF);
        step("R7", pa, 1'b0, 0, 1'b0, 0);
        // R9: alias evicts; not-taken allocation gives counter 00
        step("R9", pa, 1'b1, pb, 1'b0, 32'h0000_1234);
        step("R9", pa, 1'b0, 0, 1'b0, 0);
        step("R5", pb, 1'b0, 0, 1'b0, 0);
        // R8: same-cycle update of a hit slot, old counter visible
        step("R8", pb, 1'b1, pb, 1'b1, 32'h0000_7777);
        step("R8", pb, 1'b1, pb, 1'b1, 32'h0000_7777);
        step("R8", pb, 1'b0, 0, 1'b0, 0);

        // random traffic over colliding addresses
        for (int i = 0; i < 8; i++)
            pool[i] = mk_pc(24'($urandom_range(0, 3)), 6'(i < 4 ? 9 : $urandom_range(0, 63)));
        for (int i = 0; i < 4000; i++)
            step("R4", pool[$urandom_range(0, 7)], 1'($urandom_range(0, 1)),
                 pool[$urandom_range(0, 7)], 1'($urandom_range(0, 1)), $urandom);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule